// File: doc/BRIEF.md
# Phase-Matched Clock Divider with Release

This block takes one primary clock and a set of auxiliary clocks and re-emits them through a matched delay path. The primary clock leaves the block as an undivided delayed copy and as divide-by-2, divide-by-4 and divide-by-8 outputs. Each divided output changes only where the delayed primary copy rises, so all four primary-derived outputs share their rising edges. The auxiliary clocks are not divided. They pass through exactly the same number of stages as the primary clock, so every auxiliary output keeps its input skew to the primary output.

All inputs are sampled by a sampling clock `clk_smp` that runs faster than any clock being handled. Delays and skews are therefore counted in sampling-clock cycles. The divided outputs stay low until a release input is accepted at a rising edge of the primary clock. From that edge on they run freely until reset. A reset input clears every output at once. Leaving reset takes effect only on sampling-clock edges.

Top module: `phase_div_clkgen`

## Requirements
- R1: `main_q` equals the value of `clk_main` delayed by exactly DELAY_STAGES (default 4) cycles of `clk_smp`.
- R2: Each bit of `aux_q` equals the matching bit of `clk_aux`, delayed by the same DELAY_STAGES cycles as `main_q`. Any skew between an auxiliary input and `clk_main` therefore appears unchanged at the outputs.
- R3: Once running, `div_q[k]` divides the primary clock by 2^(k+1): bit 0 by 2, bit 1 by 4, bit 2 by 8. Each bit is high for the first half of its period. A bit changes only in a cycle in which `main_q` rises.
- R4: At the first accepted primary edge, all bits of `div_q` rise in the same cycle as `main_q`. Every time the divide-by-8 bit rises, all `div_q` bits are 1 and `main_q` rises in that same cycle.
- R5: Until a release has been accepted, `div_q` stays 0, even though `main_q` and `aux_q` toggle.
- R6: `release_in` is synchronised by SYNC_STAGES flops. It is accepted at a rising edge of the delayed primary clock. After acceptance, dropping `release_in` has no effect: `div_q` keeps dividing until reset.
- R7: While `rst` is high, `main_q`, `div_q` and `aux_q` are all 0. They clear as soon as `rst` rises, without waiting for any clock edge.
- R8: After reset the block needs a new release. With `release_in` low, `div_q` stays 0. The division restarts from its initial phase, so the first accepted edge again raises all `div_q` bits together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_smp | input | 1 | Sampling clock; all registers run on its rising edge |
| rst | input | 1 | Asynchronous reset, active high; released synchronously inside |
| clk_main | input | 1 | Primary clock to be delayed and divided |
| clk_aux | input | N_AUX | Auxiliary clocks to be delayed without division |
| release_in | input | 1 | Starts the divided outputs at the next primary rising edge |
| main_q | output | 1 | Delayed undivided primary clock |
| div_q | output | DIV_BITS | Divided primary clocks; bit k divides by 2^(k+1) |
| aux_q | output | N_AUX | Delayed auxiliary clocks |

## Verification
The hardest situation to reach is a reset that arrives while the dividers sit in the middle of a period, followed by a clean restart. This is the case that shows whether reset clears immediately and whether the phase starts over. The stimulus runs the block with release accepted and then drops release to show the dividers keep running. It then raises `rst` a few nanoseconds after a sampling edge and, in that same step, parks the input clocks. The outputs are read before the next clock edge. The primary clock is then restarted with release held low for several periods before release is given again, so the divided outputs have to begin again in phase with the delayed primary clock.

// File: rtl/phase_div_pkg.sv
package phase_div_pkg;

  // Rising transition between the stage ahead and the current output stage.
  function automatic logic rising(input logic ahead, input logic now);
    return ahead & ~now;
  endfunction

  // A primary edge advances the divider once release has been accepted,
  // or at the edge where the synchronised release is first seen.
  function automatic logic accept_edge(input logic running, input logic rel_seen,
                                       input logic edge_hit);
    return edge_hit & (running | rel_seen);
  endfunction

  // Level of divider k for a given down-count value.
  function automatic logic ratio_level(input int count_val, input int k);
    return ((count_val >> k) & 1) != 0;
  endfunction

endpackage

// File: rtl/phase_div_sync.sv
module phase_div_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) shift_q <= '0;
    else      shift_q <= {shift_q[STAGES-2:0], d};
  end

  assign q = shift_q[STAGES-1];
endmodule

// File: rtl/phase_div_tapline.sv
module phase_div_tapline #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             arst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] tap_last,
  output logic             lead_ahead
);
  logic [DEPTH-1:0][WIDTH-1:0] stage_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or posedge arst) begin
        if (arst) stage_q[0] <= '0;
        else      stage_q[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or posedge arst) begin
        if (arst) stage_q[g] <= '0;
        else      stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign tap_last   = stage_q[DEPTH-1];
  assign lead_ahead = stage_q[DEPTH-2][0];
endmodule

// File: rtl/phase_div_core.sv
module phase_div_core
  import phase_div_pkg::*;
#(
  parameter int DIV_BITS = 3
) (
  input  logic                clk,
  input  logic                arst,
  input  logic                edge_hit,
  input  logic                rel_seen,
  output logic                run_q,
  output logic [DIV_BITS-1:0] div_q
);
  localparam logic [DIV_BITS-1:0] CNT_ONE = {{(DIV_BITS-1){1'b0}}, 1'b1};

  logic [DIV_BITS-1:0] cnt_q;
  logic [DIV_BITS-1:0] cnt_d;
  logic [DIV_BITS-1:0] lvl_d;
  logic                take;

  assign take  = accept_edge(run_q, rel_seen, edge_hit);
  assign cnt_d = cnt_q - CNT_ONE;

  for (genvar k = 0; k < DIV_BITS; k++) begin : g_level
    assign lvl_d[k] = ratio_level(int'(cnt_d), k);
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      div_q <= '0;
    end else if (take) begin
      cnt_q <= cnt_d;
      run_q <= 1'b1;
      div_q <= lvl_d;
    end
  end
endmodule

// File: rtl/phase_div_clkgen.sv
module phase_div_clkgen
  import phase_div_pkg::*;
#(
  parameter int N_AUX        = 3,
  parameter int DIV_BITS     = 3,
  parameter int DELAY_STAGES = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                clk_smp,
  input  logic                rst,
  input  logic                clk_main,
  input  logic [N_AUX-1:0]    clk_aux,
  input  logic                release_in,
  output logic                main_q,
  output logic [DIV_BITS-1:0] div_q,
  output logic [N_AUX-1:0]    aux_q
);
  localparam int LANES = 1 + N_AUX;

  logic             rst_hold_n;
  logic             rst_int;
  logic             rel_seen;
  logic [LANES-1:0] lane_out;
  logic             lead_ahead;
  logic             pre_rise;
  logic             run_q;

  phase_div_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk (clk_smp), .arst(rst), .d(1'b1), .q(rst_hold_n)
  );
  assign rst_int = ~rst_hold_n;

  phase_div_sync #(.STAGES(SYNC_STAGES)) u_rel_sync (
    .clk (clk_smp), .arst(rst_int), .d(release_in), .q(rel_seen)
  );

  // Lane 0 is the primary clock; every lane shares one delay line depth.
  phase_div_tapline #(.WIDTH(LANES), .DEPTH(DELAY_STAGES)) u_taps (
    .clk       (clk_smp),
    .arst      (rst_int),
    .din       ({clk_aux, clk_main}),
    .tap_last  (lane_out),
    .lead_ahead(lead_ahead)
  );

  assign pre_rise = rising(lead_ahead, lane_out[0]);

  phase_div_core #(.DIV_BITS(DIV_BITS)) u_core (
    .clk     (clk_smp),
    .arst    (rst_int),
    .edge_hit(pre_rise),
    .rel_seen(rel_seen),
    .run_q   (run_q),
    .div_q   (div_q)
  );

  assign main_q = lane_out[0];
  assign aux_q  = lane_out[LANES-1:1];
endmodule

// File: rtl/phase_div_chk.sv
module phase_div_chk #(
  parameter int DIV_BITS = 3,
  parameter int N_AUX    = 3
) (
  input logic                clk_smp,
  input logic                rst,
  input logic                main_q,
  input logic [DIV_BITS-1:0] div_q,
  input logic [N_AUX-1:0]    aux_q,
  input logic                run_q
);
  AST_DIV_ON_MAIN_EDGE: assert property (@(posedge clk_smp) disable iff (rst)
    !$stable(div_q) |-> $rose(main_q)); // R3

  AST_ALL_RISE_TOGETHER: assert property (@(posedge clk_smp) disable iff (rst)
    $rose(div_q[DIV_BITS-1]) |-> (div_q == '1) && $rose(main_q)); // R4

  AST_IDLE_BEFORE_RUN: assert property (@(posedge clk_smp) disable iff (rst)
    !run_q |-> (div_q == '0)); // R5

  AST_RUN_STICKY: assert property (@(posedge clk_smp) disable iff (rst)
    run_q |=> run_q); // R6

  AST_RESET_CLEARS: assert property (@(posedge clk_smp)
    rst |-> (!main_q && div_q == '0 && aux_q == '0)); // R7
endmodule

bind phase_div_clkgen phase_div_chk #(.DIV_BITS(DIV_BITS), .N_AUX(N_AUX)) u_chk (
  .clk_smp(clk_smp),
  .rst    (rst),
  .main_q (main_q),
  .div_q  (div_q),
  .aux_q  (aux_q),
  .run_q  (run_q)
);

// File: tb/phase_div_clkgen_test.sv
module phase_div_clkgen_test;
  localparam int D = 4;

  typedef struct {
    int         tgt;
    logic       main;
    logic [2:0] aux;
    logic [2:0] divs;
  } item_t;

  logic       clk_smp = 1'b0;
  logic       rst = 1'b0;
  logic       clk_main = 1'b0;
  logic [2:0] clk_aux = '0;
  logic       release_in = 1'b0;
  logic       main_q;
  logic [2:0] div_q;
  logic [2:0] aux_q;

  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  bit gen_on = 1'b0;
  bit want_rel = 1'b0;
  bit finished = 1'b0;
  item_t sb_q[$];
  int rises[3];

  always #5 clk_smp = ~clk_smp;

  phase_div_clkgen uut (
    .clk_smp(clk_smp), .rst(rst), .clk_main(clk_main), .clk_aux(clk_aux),
    .release_in(release_in), .main_q(main_q), .div_q(div_q), .aux_q(aux_q)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: produces input clocks and pushes the expected outputs D cycles ahead.
  int n = 0, ph = 0, rel_idx = 0;
  bit rel_valid = 0, armed = 0, prev_pri = 0;
  logic [2:0] cnt = '0, divs = '0;
  always @(negedge clk_smp) begin
    bit pri;
    logic [2:0] aux;
    item_t it;
    n++;
    if (gen_on) begin
      pri    = (ph < 4);
      aux[0] = (((ph + 7) % 8) < 4);
      aux[1] = (((ph + 5) % 8) < 4);
      aux[2] = ((ph % 4) < 2);
      if (ph == 2) release_in = want_rel;
      ph = (ph + 1) % 8;
    end else begin
      pri = 0; aux = '0; ph = 0;
      release_in = 1'b0;
    end
    clk_main = pri;
    clk_aux  = aux;
    if (release_in && !rel_valid) begin rel_valid = 1; rel_idx = n; end
    if (!release_in && !armed) rel_valid = 0;
    if (rst) begin
      cnt = '0; divs = '0; armed = 0; rel_valid = 0;
    end else if (pri && !prev_pri && (armed || (rel_valid && rel_idx + 3 <= n + D))) begin
      armed = 1;
      cnt   = cnt - 3'd1;
      divs  = cnt;
    end
    prev_pri = pri;
    it.tgt = n + D; it.main = pri; it.aux = aux; it.divs = divs;
    sb_q.push_back(it);
  end

  // Monitor: pops the item due this cycle and compares.
  int m = 0;
  logic prev_main = 0;
  logic [2:0] prev_div = '0;
  always @(negedge clk_smp) begin
    item_t it;
    m++;
    if (sb_q.size() > 0 && sb_q[0].tgt == m) begin
      it = sb_q.pop_front();
      if (mon_on) begin
        chk("R1", "main_q", int'(main_q), int'(it.main));
        chk("R2", "aux_q", int'(aux_q), int'(it.aux));
        chk("R3", "div_q", int'(div_q), int'(it.divs));
      end
    end
    if (mon_on) begin
      for (int k = 0; k < 3; k++)
        if (div_q[k] && !prev_div[k]) rises[k]++;
      if (div_q[2] && !prev_div[2])
        chk("R4 R8", "all divided rise with main", int'({div_q, main_q && !prev_main}), 15);
    end
    prev_main = main_q;
    prev_div  = div_q;
  end

  task automatic wait_cycles(input int c);
    repeat (c) @(negedge clk_smp);
  endtask

  task automatic clear_rises();
    for (int k = 0; k < 3; k++) rises[k] = 0;
  endtask

  initial begin
    #2 rst = 1'b1;
    #1;
    chk("R7", "reset state outputs", int'({main_q, div_q, aux_q}), 0);
    mon_on = 1'b1;
    wait_cycles(5);
    #2 rst = 1'b0;
    wait_cycles(10);
    gen_on = 1'b1;
    clear_rises();
    wait_cycles(40);
    chk("R5", "div rises before release", rises[0] + rises[1] + rises[2], 0);
    chk("R5", "div_q before release", int'(div_q), 0);
    want_rel = 1'b1;
    wait_cycles(16);
    clear_rises();
    wait_cycles(256);
    chk("R3", "div2 rises in 32 periods", rises[0], 16);
    chk("R3", "div4 rises in 32 periods", rises[1], 8);
    chk("R3", "div8 rises in 32 periods", rises[2], 4);
    want_rel = 1'b0;
    wait_cycles(16);
    clear_rises();
    wait_cycles(128);
    chk("R6", "div2 rises after release dropped", rises[0], 8);
    wait_cycles(3);
    @(posedge clk_smp);
    #3;
    rst = 1'b1;
    gen_on = 1'b0;
    foreach (sb_q[i]) begin
      sb_q[i].main = 1'b0; sb_q[i].aux = '0; sb_q[i].divs = '0;
    end
    #1;
    chk("R7", "main_q right after reset", int'(main_q), 0);
    chk("R7", "div_q right after reset", int'(div_q), 0);
    chk("R7", "aux_q right after reset", int'(aux_q), 0);
    wait_cycles(5);
    #2 rst = 1'b0;
    wait_cycles(10);
    gen_on = 1'b1;
    clear_rises();
    wait_cycles(24);
    chk("R8", "div rises after reset without release", rises[0] + rises[1] + rises[2], 0);
    want_rel = 1'b1;
    wait_cycles(160);
    chk("R8", "div8 rises after new release", int'(rises[2] >= 2), 1);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule